// File: doc/BRIEF.md
# General-Purpose Port Control Register with Power-Mode Triggers

This block holds an eight-bit port's output latch and its direction register. Both sit on a small CPU data-bus slave. The low six bits of each register drive six bidirectional pins: output level and output enable. The two top positions of each register control no pins. Pin 6 is input only, and pin 7 is a clock output or a plain input. These four bits are used instead for chip-level controls.

In the output latch, the top two bits are write-only triggers. A 1 in bit 7 fires a one-cycle HALT request. A 1 in bit 6 fires a one-cycle IDLE request. Neither bit is stored, so both always read back as zero. In the direction register, the top two bits are kept as ordinary flags:
- Bit 6 selects the alternate phase of the serial shift clock.
- Bit 7 enables a clock start-up delay on leaving HALT when an RC oscillator is in use.

A third bus address returns the raw input value of all eight pins. Clock gating, the oscillator and the serial shifter are outside this block; they consume its control outputs.

Top module: `portg_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, until the first write:
  - both registers hold 0x00;
  - `pin_out` and `pin_oe` are all zero, so every pin is an input;
  - `halt_req`, `idle_req`, `sk_alt_phase` and `clk_start_dly` are low.
- R2: A write to address 0 (data) stores `bus_wdata[5:0]`. The stored value appears on `pin_out` from the cycle after the write edge. A read of address 0 returns the stored bits in [5:0].
- R3: A write to address 1 (config) stores all eight bits. Bits [5:0] appear on `pin_oe` from the cycle after the write edge; 1 means the pin is driven.
- R4: A data write with bit 7 set raises `halt_req` for exactly the one cycle after the write edge.
- R5: A data write with bit 6 set and bit 7 clear raises `idle_req` for exactly the one cycle after the write edge.
- R6: A data write with both bit 7 and bit 6 set raises only `halt_req`. HALT has priority, and `idle_req` stays low.
- R7: Data bits 7 and 6 are not stored:
  - a read of address 0 always returns 0 in bits [7:6];
  - a data write with both bits clear produces no request pulse.
- R8: Config bit 6 drives `sk_alt_phase` and config bit 7 drives `clk_start_dly`. A read of address 1 returns all eight written bits.
- R9: A read of address 2 returns `pin_in` unchanged. A read of address 3 returns 0x00.
- R10: An access with `bus_we` low changes no state, and neither does any cycle with `bus_sel` low. Writes to addresses 2 and 3 are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 config, 2 pin input, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 6 | Output levels for pins 0 to 5 |
| pin_oe | output | 6 | Output enables for pins 0 to 5 |
| halt_req | output | 1 | One-cycle HALT request |
| idle_req | output | 1 | One-cycle IDLE request |
| sk_alt_phase | output | 1 | Alternate serial-clock phase select |
| clk_start_dly | output | 1 | Start-up delay enable after HALT |

## Verification
The assertions check four things on every cycle:
- the two request strobes are never high together;
- each strobe is high only in the cycle after a matching data write;
- the pin outputs and enables do not change without a write to their own register;
- a data read never shows bits 7:6.

The bench's scenarios cover what only concrete values can show:
- the stored values and the read-back contents of each address;
- the pass-through of the pin inputs;
- that a write of zeros to the trigger bits fires nothing;
- that writes to the other addresses, reads and deselected cycles leave the state alone.

// File: rtl/portg_pkg.sv
package portg_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } portg_sel_e;

  localparam int unsigned PORT_W = 8;
  localparam int unsigned DRV_W  = 6;
endpackage

// File: rtl/portg_regfile.sv
module portg_regfile
  import portg_pkg::*;
#(
  parameter int unsigned DW = PORT_W,
  parameter int unsigned PW = DRV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_cfg,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] data_q,
  output logic [DW-1:0] cfg_q
);
  logic [PW-1:0] data_d;
  logic [DW-1:0] cfg_d;

  always_comb begin
    data_d = data_q;
    cfg_d  = cfg_q;
    if (wr_data) data_d = wdata[PW-1:0];
    if (wr_cfg)  cfg_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_data) data_q <= data_d;
      if (wr_cfg)  cfg_q  <= cfg_d;
    end
  end

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_data) |-> $stable(data_q));
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_cfg) |-> $stable(cfg_q));
endmodule

// File: rtl/portg_pwr_req.sv
module portg_pwr_req (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_data,
  input  logic halt_bit,
  input  logic idle_bit,
  output logic halt_req,
  output logic idle_req
);
  logic halt_d, idle_d;

  always_comb begin
    halt_d = wr_data & halt_bit;
    idle_d = wr_data & idle_bit & ~halt_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req <= 1'b0;
      idle_req <= 1'b0;
    end else begin
      halt_req <= halt_d;
      idle_req <= idle_d;
    end
  end

  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && idle_req));
  // R4
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr_data && halt_bit));
  // R5
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |-> $past(wr_data && idle_bit && !halt_bit));
endmodule

// File: rtl/portg_rdmux.sv
module portg_rdmux
  import portg_pkg::*;
#(
  parameter int unsigned DW = PORT_W,
  parameter int unsigned PW = DRV_W
) (
  input  portg_sel_e    sel,
  input  logic [PW-1:0] data_q,
  input  logic [DW-1:0] cfg_q,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] rdata
);
  localparam int unsigned PAD = DW - PW;

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = {{PAD{1'b0}}, data_q};
      SEL_CFG:  rdata = cfg_q;
      SEL_PIN:  rdata = pin_in;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/portg_ctl.sv
module portg_ctl
  import portg_pkg::*;
#(
  parameter int unsigned DW = PORT_W,
  parameter int unsigned PW = DRV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_in,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe,
  output logic          halt_req,
  output logic          idle_req,
  output logic          sk_alt_phase,
  output logic          clk_start_dly
);
  localparam int unsigned HALT_POS = DW - 1;
  localparam int unsigned IDLE_POS = DW - 2;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  portg_sel_e    sel;
  logic          wr_data, wr_cfg;
  logic [PW-1:0] data_q;
  logic [DW-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    sel     = portg_sel_e'(bus_addr);
    wr_data = bus_sel & bus_we & (sel == SEL_DATA);
    wr_cfg  = bus_sel & bus_we & (sel == SEL_CFG);
  end

  portg_regfile #(.DW(DW), .PW(PW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_data(wr_data),
    .wr_cfg (wr_cfg),
    .wdata  (bus_wdata),
    .data_q (data_q),
    .cfg_q  (cfg_q)
  );

  portg_pwr_req u_pwr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_data (wr_data),
    .halt_bit(bus_wdata[HALT_POS]),
    .idle_bit(bus_wdata[IDLE_POS]),
    .halt_req(halt_req),
    .idle_req(idle_req)
  );

  portg_rdmux #(.DW(DW), .PW(PW)) u_rd (
    .sel   (sel),
    .data_q(data_q),
    .cfg_q (cfg_q),
    .pin_in(pin_in),
    .rdata (bus_rdata)
  );

  assign pin_out       = data_q;
  assign pin_oe        = cfg_q[PW-1:0];
  assign sk_alt_phase  = cfg_q[IDLE_POS];
  assign clk_start_dly = cfg_q[HALT_POS];

  // R7
  data_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == 2'd0) |-> (bus_rdata[HALT_POS:IDLE_POS] == 2'b00));
  // R8
  ctl_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(bus_sel && bus_we && bus_addr == 2'd1) |->
      ($stable(sk_alt_phase) && $stable(clk_start_dly)));
endmodule

// File: tb/sim_portg_ctl.sv
module sim_portg_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, pin_in = 8'h00;
  logic [7:0] bus_rdata;
  logic [5:0] pin_out, pin_oe;
  logic       halt_req, idle_req, sk_alt_phase, clk_start_dly;

  int checks = 0, fails = 0, cycles = 0;
  int m_data = 0, m_cfg = 0, m_halt = 0, m_idle = 0;

  always #10 clk = ~clk;

  portg_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .halt_req(halt_req), .idle_req(idle_req),
    .sk_alt_phase(sk_alt_phase), .clk_start_dly(clk_start_dly)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int exp_rd;
    case (bus_addr)
      2'd0: exp_rd = m_data & 8'h3f;
      2'd1: exp_rd = m_cfg;
      2'd2: exp_rd = int'(pin_in);
      default: exp_rd = 0;
    endcase
    chk(tag, "pin_out", int'(pin_out), m_data & 8'h3f);
    chk(tag, "pin_oe", int'(pin_oe), m_cfg & 8'h3f);
    chk(tag, "halt_req", int'(halt_req), m_halt);
    chk(tag, "idle_req", int'(idle_req), m_idle);
    chk(tag, "sk_alt_phase", int'(sk_alt_phase), (m_cfg >> 6) & 1);
    chk(tag, "clk_start_dly", int'(clk_start_dly), (m_cfg >> 7) & 1);
    chk(tag, "bus_rdata", int'(bus_rdata), exp_rd);
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(input string tag, input logic s, input logic w,
                      input logic [1:0] a, input logic [7:0] d, input logic [7:0] p);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; pin_in = p;
    @(posedge clk);
    m_halt = 0; m_idle = 0;
    if (s && w && a == 2'd0) begin
      m_data = int'(d) & 8'h3f;
      m_halt = d[7];
      m_idle = d[6] & ~d[7];
    end else if (s && w && a == 2'd1) begin
      m_cfg = int'(d);
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected <20000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step("R1", 1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    step("R1", 1'b1, 1'b0, 2'd1, 8'h00, 8'h00);
    // R2 data stores low bits
    step("R2", 1'b1, 1'b1, 2'd0, 8'h2a, 8'h00);
    step("R2", 1'b1, 1'b0, 2'd0, 8'h00, 8'h00);
    step("R2", 1'b1, 1'b1, 2'd0, 8'h15, 8'h00);
    // R3 direction
    step("R3", 1'b1, 1'b1, 2'd1, 8'h3c, 8'h00);
    step("R3", 1'b1, 1'b1, 2'd1, 8'h03, 8'h00);
    // R4 halt pulse, then idle cycle
    step("R4", 1'b1, 1'b1, 2'd0, 8'h81, 8'h00);
    step("R4", 1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    // R5 idle pulse
    step("R5", 1'b1, 1'b1, 2'd0, 8'h42, 8'h00);
    step("R5", 1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    // R6 both set
    step("R6", 1'b1, 1'b1, 2'd0, 8'hc7, 8'h00);
    step("R6", 1'b1, 1'b1, 2'd0, 8'hff, 8'h00);
    // R7 zero trigger bits, readback zero
    step("R7", 1'b1, 1'b1, 2'd0, 8'h3f, 8'h00);
    step("R7", 1'b1, 1'b0, 2'd0, 8'h00, 8'h00);
    // R8 config flags
    step("R8", 1'b1, 1'b1, 2'd1, 8'h40, 8'h00);
    step("R8", 1'b1, 1'b1, 2'd1, 8'h80, 8'h00);
    step("R8", 1'b1, 1'b1, 2'd1, 8'hc5, 8'h00);
    step("R8", 1'b1, 1'b0, 2'd1, 8'h00, 8'h00);
    // R9 pin read and unused address
    step("R9", 1'b1, 1'b0, 2'd2, 8'h00, 8'ha5);
    step("R9", 1'b1, 1'b0, 2'd2, 8'h00, 8'h5a);
    step("R9", 1'b1, 1'b0, 2'd3, 8'h00, 8'hff);
    // R10 ignored accesses
    step("R10", 1'b0, 1'b1, 2'd0, 8'hff, 8'h00);
    step("R10", 1'b0, 1'b1, 2'd1, 8'h00, 8'h00);
    step("R10", 1'b1, 1'b1, 2'd2, 8'hff, 8'h00);
    step("R10", 1'b1, 1'b1, 2'd3, 8'hff, 8'h00);
    step("R10", 1'b1, 1'b0, 2'd0, 8'hff, 8'h00);
    step("R10", 1'b1, 1'b0, 2'd1, 8'h00, 8'h00);
    // R4 back-to-back halts
    step("R4", 1'b1, 1'b1, 2'd0, 8'h80, 8'h00);
    step("R4", 1'b1, 1'b1, 2'd0, 8'h80, 8'h00);
    step("R4", 1'b0, 1'b0, 2'd0, 8'h00, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule